// File: doc/BRIEF.md
# Periodic Tick and Interrupt Controller

This block sits beside a real-time clock core and turns the sub-second prescaler into interrupt sources. A single-cycle strobe arriving at 1024 Hz advances a ten-stage binary divider; the divider's carry points give event taps at 512, 256, 128, 64, 32, 16, 8, 4 and 2 Hz, and a once-per-second tap. Two further event pulses, from the alarm comparator and the stopwatch of the clock core, enter as inputs.

Every event sets a sticky bit in a 16-bit status word. A 16-bit enable word masks those bits, and one interrupt line is high whenever any pending bit is also enabled. Software clears pending bits by writing ones to the status word. The clock core owns the address decode: it hands this block a pre-decoded write strobe with a register select and reads both words back through the exported status and enable buses.

Top module: `tick_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the status word, the enable word and the divider are cleared, and `irq` is low.
- R2: The divider counts strobes on `tick_1024`. Taking n as the number of strobes seen since reset, the tap of rate 1024/2^k Hz fires on the strobe for which n is a multiple of 2^k. Its status bit is: 512 Hz bit 15, 256 Hz bit 14, 128 Hz bit 13, 64 Hz bit 12, 32 Hz bit 11, 16 Hz bit 10, 8 Hz bit 9, 4 Hz bit 8, 2 Hz bit 7.
- R3: The once-per-second tap (k = 10) sets status bit 4, first on the 1024th strobe.
- R4: A high `alarm_evt` sets status bit 2; a high `stopwatch_evt` sets status bit 0.
- R5: A status write (`reg_wr` high, `reg_sel` = 0) clears every implemented bit whose data bit is 1 and leaves bits whose data bit is 0 unchanged; writing 16'hFFFF clears all pending bits.
- R6: If an event and a clearing write hit the same status bit in one cycle, the bit ends set.
- R7: Status bits are set regardless of the enable word; a pending masked bit keeps `irq` low.
- R8: `irq` is high exactly when status AND enable is non-zero, in the same cycle as the registers that cause it.
- R9: An enable write (`reg_wr` high, `reg_sel` = 1) replaces the enable word with the written data; bits 1, 3, 5 and 6 always read 0. Without such a write the enable word holds.
- R10: Status bits 1, 3, 5 and 6 always read 0; writes to them have no effect.
- R11: Without a strobe the divider holds and no tap fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1024 | input | 1 | One-cycle strobe at 1024 Hz from the prescaler |
| alarm_evt | input | 1 | Alarm match event pulse |
| stopwatch_evt | input | 1 | Stopwatch expiry event pulse |
| reg_wr | input | 1 | Pre-decoded register write strobe |
| reg_sel | input | 1 | 0 selects the status word, 1 the enable word |
| reg_wdata | input | 16 | Write data |
| status_out | output | 16 | Current status word |
| enable_out | output | 16 | Current enable word |
| irq | output | 1 | Interrupt request |

## Verification
Every event, strobe and write is sampled at one clock edge and shows in `status_out` or `enable_out` directly after that edge, while `irq` follows those registers with no further delay. The bench therefore drives inputs at the falling edge, lets its behavioural model take the same rising edge, and compares all three outputs at the next falling edge, one cycle after the stimulus. Directed checks reuse that rhythm: each stimulus occupies exactly one cycle and its result is sampled at the falling edge that closes it, so the tap counts, the 1024th-strobe second and the same-cycle collision land on known cycles.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;

    localparam int REG_W      = 16;
    localparam int DIV_STAGES = 10;
    localparam int FAST_TAPS  = 8;

    // Bits that physically exist in the status and enable words.
    localparam logic [REG_W-1:0] IMPL_MASK = 16'hFF95;

    localparam int BIT_STOPWATCH = 0;
    localparam int BIT_ALARM     = 2;
    localparam int BIT_SECOND    = 4;
    localparam int BIT_HALF      = 7;

    typedef logic [REG_W-1:0] irq_word_t;
    typedef logic [DIV_STAGES:1] tap_vec_t;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic      wr_status;
        logic      wr_enable;
        irq_word_t data;
    } reg_cmd_t;

    // Status bit that carries divider tap k (rate 1024 / 2^k Hz).
    function automatic int tap_bit(input int k);
        if (k <= FAST_TAPS) return REG_W - k;
        else if (k == DIV_STAGES - 1) return BIT_HALF;
        else return BIT_SECOND;
    endfunction

    function automatic irq_word_t taps_to_word(input tap_vec_t taps);
        irq_word_t w;
        w = '0;
        for (int k = 1; k <= DIV_STAGES; k++) begin
            if (taps[k]) w[tap_bit(k)] = 1'b1;
        end
        return w;
    endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider
    import tick_irq_pkg::*;
#(
    parameter int STAGES = DIV_STAGES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            strobe,
    output logic [STAGES:1] taps
);
    localparam logic [STAGES-1:0] ONE = {{(STAGES-1){1'b0}}, 1'b1};

    logic [STAGES-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)         cnt <= '0;
        else if (strobe) cnt <= cnt + ONE;
    end

    // Tap k fires when this strobe carries out of the low k stages.
    generate
        for (genvar k = 1; k <= STAGES; k++) begin : g_tap
            assign taps[k] = strobe & (&cnt[k-1:0]);
            if (k >= 2) begin : g_nest
                assert_nested_R2: assert property (@(posedge clk) disable iff (rst)
                    taps[k] |-> taps[k-1]);
            end
        end
    endgenerate

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(cnt));

    assert_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !strobe |-> (taps == '0));

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import tick_irq_pkg::*;
#(
    parameter int             W    = REG_W,
    parameter logic [W-1:0]   MASK = IMPL_MASK
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] status
);
    logic [W-1:0] clr_vec;
    assign clr_vec = clr_wr ? clr_data : '0;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (MASK[i]) begin : g_impl
                logic pend;
                always_ff @(posedge clk) begin
                    if (rst)             pend <= 1'b0;
                    else if (evt[i])     pend <= 1'b1;
                    else if (clr_vec[i]) pend <= 1'b0;
                end
                assign status[i] = pend;
            end else begin : g_none
                assign status[i] = 1'b0;
            end
        end
    endgenerate

    assert_event_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (|(evt & MASK)) |=> ((status & $past(evt & MASK)) == $past(evt & MASK)));

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((status & $past(clr_data & ~evt)) == '0));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (|status) |=> ((($past(status) & ~$past(clr_vec)) & ~status) == '0));

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
    import tick_irq_pkg::*;
#(
    parameter int           W    = REG_W,
    parameter logic [W-1:0] MASK = IMPL_MASK
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en
);
    always_ff @(posedge clk) begin
        if (rst)     en <= '0;
        else if (wr) en <= wdata & MASK;
    end

    assert_write_R9: assert property (@(posedge clk) disable iff (rst)
        wr |=> (en == ($past(wdata) & MASK)));

    assert_keep_R9: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(en));

endmodule

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl
    import tick_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_1024,
    input  logic             alarm_evt,
    input  logic             stopwatch_evt,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] status_out,
    output logic [REG_W-1:0] enable_out,
    output logic             irq
);
    tap_vec_t  taps;
    irq_word_t events;
    reg_cmd_t  cmd;

    tick_divider #(.STAGES(DIV_STAGES)) u_div (
        .clk    (clk),
        .rst    (rst),
        .strobe (tick_1024),
        .taps   (taps)
    );

    always_comb begin
        events                = taps_to_word(taps);
        events[BIT_ALARM]     = events[BIT_ALARM] | alarm_evt;
        events[BIT_STOPWATCH] = events[BIT_STOPWATCH] | stopwatch_evt;
    end

    always_comb begin
        cmd.wr_status = reg_wr && (reg_sel_e'(reg_sel) == SEL_STATUS);
        cmd.wr_enable = reg_wr && (reg_sel_e'(reg_sel) == SEL_ENABLE);
        cmd.data      = reg_wdata;
    end

    irq_status_reg #(.W(REG_W), .MASK(IMPL_MASK)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .evt      (events),
        .clr_wr   (cmd.wr_status),
        .clr_data (cmd.data),
        .status   (status_out)
    );

    irq_enable_reg #(.W(REG_W), .MASK(IMPL_MASK)) u_en (
        .clk   (clk),
        .rst   (rst),
        .wr    (cmd.wr_enable),
        .wdata (cmd.data),
        .en    (enable_out)
    );

    assign irq = |(status_out & enable_out);

    assert_alarm_R4: assert property (@(posedge clk) disable iff (rst)
        alarm_evt |=> status_out[BIT_ALARM]);

    assert_stopwatch_R4: assert property (@(posedge clk) disable iff (rst)
        stopwatch_evt |=> status_out[BIT_STOPWATCH]);

    assert_masked_R7: assert property (@(posedge clk) disable iff (rst)
        (enable_out == '0) |-> !irq);

endmodule

// File: tb/sim_tick_irq_ctrl.sv
`timescale 1ns/100ps
module sim_tick_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe = 1'b0, al = 1'b0, sw = 1'b0, wr = 1'b0, sel = 1'b0;
    logic [15:0] wd = '0;
    logic [15:0] st, en;
    logic        irq;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    // behavioural reference
    int          m_cnt  = 0;
    logic [15:0] m_stat = '0;
    logic [15:0] m_en   = '0;
    localparam logic [15:0] LIVE = 16'b1111_1111_1001_0101;

    always #2.5 clk = ~clk;

    tick_irq_ctrl u0 (
        .clk(clk), .rst(rst), .tick_1024(strobe), .alarm_evt(al),
        .stopwatch_evt(sw), .reg_wr(wr), .reg_sel(sel), .reg_wdata(wd),
        .status_out(st), .enable_out(en), .irq(irq)
    );

    function automatic int pos_of_rate(input int k);
        case (k)
            1: return 15;  2: return 14;  3: return 13;  4: return 12;
            5: return 11;  6: return 10;  7: return 9;   8: return 8;
            9: return 7;   default: return 4;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [15:0] ev, clr;
        if (rst) begin
            m_cnt = 0; m_stat = '0; m_en = '0;
        end else begin
            ev = '0;
            if (strobe) begin
                m_cnt = m_cnt + 1;
                for (int k = 1; k <= 10; k++)
                    if (m_cnt % (1 << k) == 0) ev[pos_of_rate(k)] = 1'b1;
                m_cnt = m_cnt % 1024;
            end
            if (al) ev[2] = 1'b1;
            if (sw) ev[0] = 1'b1;
            clr = (wr && !sel) ? wd : 16'h0000;
            m_stat = ((m_stat & ~clr) | ev) & LIVE;
            if (wr && sel) m_en = wd & LIVE;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // model comparison every cycle, away from the rising edge
    always @(negedge clk) begin
        chk(st === m_stat, "R2 R4 R5 R6 R10 status vs model", st, m_stat);
        chk(en === m_en, "R9 enable vs model", en, m_en);
        chk(irq === |(m_stat & m_en), "R8 irq vs model", {15'b0, irq}, {15'b0, |(m_stat & m_en)});
    end

    task automatic cyc(input logic s, input logic a, input logic w_sw,
                       input logic wrv, input logic selv, input logic [15:0] d);
        strobe = s; al = a; sw = w_sw; wr = wrv; sel = selv; wd = d;
        @(negedge clk);
        strobe = 0; al = 0; sw = 0; wr = 0; sel = 0; wd = '0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk(st === 16'h0 && en === 16'h0 && irq === 1'b0, "R1 reset state", st, 16'h0);
        rst = 1'b0;

        cyc(1, 0, 0, 0, 0, 0);
        chk(st === 16'h0000, "R2 first strobe no tap", st, 16'h0000);
        cyc(1, 0, 0, 0, 0, 0);
        chk(st === 16'h8000, "R2 512Hz on strobe 2", st, 16'h8000);
        cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        chk(st === 16'hC000, "R2 256Hz on strobe 4", st, 16'hC000);
        repeat (1019) cyc(1, 0, 0, 0, 0, 0);
        chk(st === 16'hFF80, "R3 no second yet at strobe 1023", st, 16'hFF80);
        cyc(1, 0, 0, 0, 0, 0);
        chk(st === 16'hFF90, "R3 second tap at strobe 1024", st, 16'hFF90);
        chk(irq === 1'b0, "R7 masked pending keeps irq low", {15'b0, irq}, 16'h0);

        cyc(0, 0, 0, 1, 0, 16'hFFFF);
        chk(st === 16'h0000, "R5 all-ones clear", st, 16'h0000);
        repeat (20) cyc(0, 0, 0, 0, 0, 0);
        chk(st === 16'h0000, "R11 idle without strobe", st, 16'h0000);
        cyc(1, 0, 0, 0, 0, 0);
        chk(st === 16'h0000, "R11 divider held during idle", st, 16'h0000);

        cyc(0, 0, 0, 1, 1, 16'hFFFF);
        chk(en === 16'hFF95, "R9 enable write, holes read 0", en, 16'hFF95);
        chk(irq === 1'b0, "R8 nothing pending", {15'b0, irq}, 16'h0);
        cyc(0, 1, 0, 0, 0, 0);
        chk(st === 16'h0004, "R4 alarm sets bit 2", st, 16'h0004);
        chk(irq === 1'b1, "R8 enabled alarm raises irq", {15'b0, irq}, 16'h1);
        cyc(0, 0, 1, 0, 0, 0);
        chk(st === 16'h0005, "R4 stopwatch sets bit 0", st, 16'h0005);
        cyc(0, 0, 0, 1, 1, 16'h0004);
        chk(en === 16'h0004, "R9 enable rewrite", en, 16'h0004);
        cyc(0, 0, 0, 1, 0, 16'h0004);
        chk(st === 16'h0001, "R5 clear one bit, keep other", st, 16'h0001);
        chk(irq === 1'b0, "R8 irq drops after clear", {15'b0, irq}, 16'h0);
        cyc(0, 1, 0, 1, 0, 16'h0004);
        chk(st === 16'h0005, "R6 event beats clear", st, 16'h0005);
        cyc(0, 0, 0, 1, 0, 16'h006A);
        chk(st === 16'h0005, "R10 writes to holes ignored", st, 16'h0005);
        cyc(0, 0, 0, 1, 1, 16'h006A);
        chk(en === 16'h0000, "R9 enable holes read 0", en, 16'h0000);
        chk(irq === 1'b0 && st === 16'h0005, "R7 pending while masked", st, 16'h0005);

        for (int i = 0; i < 2000; i++) begin
            cyc($urandom_range(1, 0) == 1, $urandom_range(15, 0) == 0,
                $urandom_range(15, 0) == 0, $urandom_range(7, 0) == 0,
                $urandom_range(1, 0) == 1, 16'($urandom));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule